// File: doc/BRIEF.md
# Split DC-Link Balance Compensator

This block adjusts two PWM compare values, one for the main phase and one for the auxiliary phase, so that the inverter output stays correct when the two capacitors of a split DC bus carry unequal voltages. Each operation starts with a one-cycle start pulse. At that pulse the block captures both uncompensated compare values, the timer period, the total bus voltage, the measured bottom-capacitor voltage, the ideal top and bottom reference voltages (Q15), and an enable switch.

When the switch is off, the compare values pass straight through. When it is on, the block first forms a reciprocal of the total bus voltage, one quotient bit per cycle. It then runs the main phase and the auxiliary phase in turn through one shared multiplier, solving a charge-balance equation for each. Each result is held inside guard margins of the timer period. The absolute change of each compare value is reported with it. A done pulse marks the cycle in which all four results are valid.

If the total bus voltage is zero, the block does not divide. It keeps the previous results and only pulses done.

Top module: `ripple_comp`

## Requirements
- R1: With the enable switch low at start, the next cycle shows the captured compare inputs unchanged on both compare outputs and zero on both difference outputs, with done high.
- R2: The reciprocal is floor(0x7FFF * 2^11 / Vtotal) kept to its low 15 bits (Q11). It is built by restoring division, one quotient bit per cycle, and the partial remainder always stays below the divisor.
- R3: For each phase with old compare Tx and period T, the unclamped result is ((T*Vtop_act >>> 15) - V) * recip >>> 11. Here Vtop_act = Vtotal - Vbottom and V = ((T - Tx)*Vref_top >>> 15) - (Tx*Vref_bot >>> 15), using signed floor shifts.
- R4: A result greater than or equal to T is replaced by T - 5.
- R5: A result less than or equal to zero is replaced by 5.
- R6: Each difference output equals the absolute value of the captured old compare minus the new compare for its phase.
- R7: With the enable switch high and a total bus voltage of zero, no division is started. The compare and difference outputs keep their values and done still pulses in the next cycle.
- R8: Done is high for exactly one cycle per accepted start. The output registers change only in a cycle where done is high.
- R9: After reset, all four data outputs are zero, and done and busy are low.
- R10: Operands are captured at the accepted start. While busy is high, further start pulses and input changes have no effect on the results of the operation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request that captures all operands |
| comp_en_i | input | 1 | 1 = compensate, 0 = pass through |
| cmp_a_i | input | 16 | Uncompensated main-phase compare value |
| cmp_b_i | input | 16 | Uncompensated auxiliary-phase compare value |
| period_i | input | 16 | Timer period in counts |
| vbus_total_i | input | 16 | Measured total bus voltage (Q15) |
| vbus_bot_i | input | 16 | Measured bottom-capacitor voltage (Q15) |
| vref_top_i | input | 16 | Ideal top-capacitor voltage (Q15) |
| vref_bot_i | input | 16 | Ideal bottom-capacitor voltage (Q15) |
| cmp_a_o | output | 16 | Resulting main-phase compare value |
| cmp_b_o | output | 16 | Resulting auxiliary-phase compare value |
| diff_a_o | output | 16 | Absolute change of the main-phase compare |
| diff_b_o | output | 16 | Absolute change of the auxiliary-phase compare |
| done_o | output | 1 | Results valid this cycle |
| busy_o | output | 1 | Operation in progress |

## Verification
The assertions check four things on every cycle. They check that the divider remainder stays below the divisor and that a zero divisor is never started. They check that every clamped result falls strictly between zero and the period. They check that the outputs move only together with done, and that bypass and zero-voltage starts behave as stated. Only the bench scenarios can show that the numbers are right: the reciprocal scaling, the sign handling in the balance equation, which clamp branch is chosen, and that a start during a busy operation changes nothing. The bench compares each result against a software model of the balance equation, across random bus voltages, references and periods.

// File: rtl/ripple_pkg.sv
package ripple_pkg;
    localparam int RP_W     = 16;
    localparam int RP_FRAC  = 11;
    localparam int RP_QREF  = 15;
    localparam int RP_GUARD = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV,
        ST_TOPV,
        ST_M1,
        ST_M2,
        ST_M4
    } rc_state_e;
endpackage

// File: rtl/ripple_mul.sv
module ripple_mul #(
    parameter int AW  = 20,
    parameter int BW  = 17,
    parameter int SHA = 15,
    parameter int SHB = 11,
    localparam int PW = AW + BW
) (
    input  logic signed [AW-1:0] a_i,
    input  logic signed [BW-1:0] b_i,
    input  logic                 sel_b_i,
    output logic signed [PW-1:0] p_o
);
    logic signed [PW-1:0] full;

    always_comb begin
        full = a_i * b_i;
        if (sel_b_i) begin
            p_o = full >>> SHB;
        end else begin
            p_o = full >>> SHA;
        end
    end
endmodule

// File: rtl/ripple_recip.sv
module ripple_recip #(
    parameter int W    = 16,
    parameter int FRAC = 11,
    localparam int NUM_W = (W - 1) + FRAC,
    localparam int CW    = $clog2(NUM_W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] div_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-2:0] recip_o
);
    localparam logic [NUM_W-1:0] NUMER = {{(W - 1){1'b1}}, {FRAC{1'b0}}};

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CW-1:0]    cnt;
        logic [NUM_W-1:0] num;
        logic [W-1:0]     rem;
        logic [W-1:0]     dvs;
        logic [W-2:0]     quo;
    } rcp_t;

    rcp_t r_d, r_q;
    logic [W:0] trial;
    logic       take;

    always_comb begin
        r_d   = r_q;
        r_d.done = 1'b0;
        trial = {r_q.rem, r_q.num[NUM_W-1]};
        take  = (trial >= {1'b0, r_q.dvs});
        if (start_i && !r_q.busy) begin
            r_d.busy = 1'b1;
            r_d.cnt  = CW'(NUM_W);
            r_d.num  = NUMER;
            r_d.rem  = '0;
            r_d.dvs  = div_i;
            r_d.quo  = '0;
        end else if (r_q.busy) begin
            r_d.num = {r_q.num[NUM_W-2:0], 1'b0};
            r_d.rem = take ? W'(trial - {1'b0, r_q.dvs}) : W'(trial);
            r_d.quo = {r_q.quo[W-3:0], take};
            r_d.cnt = r_q.cnt - 1'b1;
            if (r_q.cnt == CW'(1)) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o  = r_q.busy;
    assign done_o  = r_q.done;
    assign recip_o = r_q.quo;

    assert_rem_below_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.busy |-> (r_q.rem < r_q.dvs));

    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.busy |-> (r_q.cnt != '0 && r_q.cnt <= CW'(NUM_W)));

    assert_no_zero_divisor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !r_q.busy) |-> (div_i != '0));
endmodule

// File: rtl/ripple_clamp.sv
module ripple_clamp #(
    parameter int W     = 16,
    parameter int PW    = 37,
    parameter int GUARD = 5
) (
    input  logic signed [PW-1:0] val_i,
    input  logic [W-1:0]         per_i,
    input  logic [W-1:0]         old_i,
    output logic [W-1:0]         res_o,
    output logic [W-1:0]         diff_o
);
    logic signed [PW-1:0] per_s;

    always_comb begin
        per_s = $signed({{(PW - W){1'b0}}, per_i});
        if (val_i >= per_s) begin
            res_o = per_i - W'(GUARD);
        end else if (val_i <= 0) begin
            res_o = W'(GUARD);
        end else begin
            res_o = val_i[W-1:0];
        end
        diff_o = (old_i >= res_o) ? (old_i - res_o) : (res_o - old_i);
    end
endmodule

// File: rtl/ripple_comp.sv
module ripple_comp
    import ripple_pkg::*;
#(
    parameter int W     = RP_W,
    parameter int FRAC  = RP_FRAC,
    parameter int QREF  = RP_QREF,
    parameter int GUARD = RP_GUARD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         comp_en_i,
    input  logic [W-1:0] cmp_a_i,
    input  logic [W-1:0] cmp_b_i,
    input  logic [W-1:0] period_i,
    input  logic [W-1:0] vbus_total_i,
    input  logic [W-1:0] vbus_bot_i,
    input  logic [W-1:0] vref_top_i,
    input  logic [W-1:0] vref_bot_i,
    output logic [W-1:0] cmp_a_o,
    output logic [W-1:0] cmp_b_o,
    output logic [W-1:0] diff_a_o,
    output logic [W-1:0] diff_b_o,
    output logic         done_o,
    output logic         busy_o
);
    localparam int AW = W + 4;
    localparam int BW = W + 1;
    localparam int PW = AW + BW;

    typedef struct packed {
        rc_state_e           st;
        logic                ph;
        logic [W-1:0]        ta;
        logic [W-1:0]        tb;
        logic [W-1:0]        per;
        logic [W-1:0]        vtot;
        logic [W-1:0]        vbot;
        logic [W-1:0]        rt;
        logic [W-1:0]        rb;
        logic signed [AW-1:0] tv;
        logic signed [AW-1:0] v;
        logic signed [AW-1:0] x;
        logic [W-1:0]        na;
        logic [W-1:0]        da;
        logic [W-1:0]        oa;
        logic [W-1:0]        ob;
        logic [W-1:0]        oda;
        logic [W-1:0]        odb;
        logic                done;
    } regs_t;

    regs_t s_d, s_q;

    logic                 div_start;
    logic                 div_busy;
    logic                 div_done;
    logic [W-2:0]         recip;
    logic [W-1:0]         ta_sel;
    logic signed [W:0]    vtop_s;
    logic signed [AW-1:0] mul_a;
    logic signed [BW-1:0] mul_b;
    logic                 mul_sel;
    logic signed [PW-1:0] mul_p;
    logic [W-1:0]         cl_res;
    logic [W-1:0]         cl_diff;

    // Operand steering for the single shared multiplier
    always_comb begin
        ta_sel  = s_q.ph ? s_q.tb : s_q.ta;
        vtop_s  = $signed({1'b0, s_q.vtot}) - $signed({1'b0, s_q.vbot});
        mul_a   = '0;
        mul_b   = '0;
        mul_sel = 1'b0;
        case (s_q.st)
            ST_TOPV: begin
                mul_a = {{(AW - W - 1){vtop_s[W]}}, vtop_s};
                mul_b = $signed({1'b0, s_q.per});
            end
            ST_M1: begin
                mul_a = $signed({{(AW - W){1'b0}}, s_q.rt});
                mul_b = $signed({1'b0, s_q.per}) - $signed({1'b0, ta_sel});
            end
            ST_M2: begin
                mul_a = $signed({{(AW - W){1'b0}}, s_q.rb});
                mul_b = $signed({1'b0, ta_sel});
            end
            ST_M4: begin
                mul_a   = s_q.x;
                mul_b   = $signed({2'b00, recip});
                mul_sel = 1'b1;
            end
            default: begin
                mul_a = '0;
            end
        endcase
    end

    ripple_mul #(
        .AW  (AW),
        .BW  (BW),
        .SHA (QREF),
        .SHB (FRAC)
    ) u_mul (
        .a_i     (mul_a),
        .b_i     (mul_b),
        .sel_b_i (mul_sel),
        .p_o     (mul_p)
    );

    ripple_clamp #(
        .W     (W),
        .PW    (PW),
        .GUARD (GUARD)
    ) u_clamp (
        .val_i  (mul_p),
        .per_i  (s_q.per),
        .old_i  (ta_sel),
        .res_o  (cl_res),
        .diff_o (cl_diff)
    );

    ripple_recip #(
        .W    (W),
        .FRAC (FRAC)
    ) u_recip (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .div_i   (s_d.vtot),
        .busy_o  (div_busy),
        .done_o  (div_done),
        .recip_o (recip)
    );

    // Next-state computation
    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        div_start = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.ta   = cmp_a_i;
                    s_d.tb   = cmp_b_i;
                    s_d.per  = period_i;
                    s_d.vtot = vbus_total_i;
                    s_d.vbot = vbus_bot_i;
                    s_d.rt   = vref_top_i;
                    s_d.rb   = vref_bot_i;
                    s_d.ph   = 1'b0;
                    if (!comp_en_i) begin
                        s_d.oa   = cmp_a_i;
                        s_d.ob   = cmp_b_i;
                        s_d.oda  = '0;
                        s_d.odb  = '0;
                        s_d.done = 1'b1;
                    end else if (vbus_total_i == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        div_start = 1'b1;
                        s_d.st    = ST_DIV;
                    end
                end
            end
            ST_DIV: begin
                if (div_done) begin
                    s_d.st = ST_TOPV;
                end
            end
            ST_TOPV: begin
                s_d.tv = AW'(mul_p);
                s_d.st = ST_M1;
            end
            ST_M1: begin
                s_d.v  = AW'(mul_p);
                s_d.st = ST_M2;
            end
            ST_M2: begin
                s_d.x  = s_q.tv - (s_q.v - AW'(mul_p));
                s_d.st = ST_M4;
            end
            ST_M4: begin
                if (!s_q.ph) begin
                    s_d.na = cl_res;
                    s_d.da = cl_diff;
                    s_d.ph = 1'b1;
                    s_d.st = ST_M1;
                end else begin
                    s_d.oa   = s_q.na;
                    s_d.oda  = s_q.da;
                    s_d.ob   = cl_res;
                    s_d.odb  = cl_diff;
                    s_d.done = 1'b1;
                    s_d.st   = ST_IDLE;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmp_a_o  = s_q.oa;
    assign cmp_b_o  = s_q.ob;
    assign diff_a_o = s_q.oda;
    assign diff_b_o = s_q.odb;
    assign done_o   = s_q.done;
    assign busy_o   = (s_q.st != ST_IDLE);

    assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !comp_en_i) |=>
            (cmp_a_o == $past(cmp_a_i) && cmp_b_o == $past(cmp_b_i) &&
             diff_a_o == '0 && diff_b_o == '0 && done_o));

    assert_clamp_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_M4 && s_q.per > W'(GUARD)) |->
            (cl_res != '0 && cl_res < s_q.per));

    assert_zero_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && comp_en_i && vbus_total_i == '0) |=>
            ($stable(cmp_a_o) && $stable(cmp_b_o) && $stable(diff_a_o) &&
             $stable(diff_b_o) && done_o && !div_busy));

    assert_change_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_a_o != $past(cmp_a_o) || cmp_b_o != $past(cmp_b_o) ||
         diff_a_o != $past(diff_a_o) || diff_b_o != $past(diff_b_o)) |-> done_o);

    assert_idle_during_div_R10: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> (s_q.st == ST_DIV));
endmodule

// File: tb/ripple_comp_tb.sv
module ripple_comp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        comp_en_i = 1'b0;
    logic [15:0] cmp_a_i = '0, cmp_b_i = '0, period_i = '0;
    logic [15:0] vbus_total_i = '0, vbus_bot_i = '0, vref_top_i = '0, vref_bot_i = '0;
    logic [15:0] cmp_a_o, cmp_b_o, diff_a_o, diff_b_o;
    logic        done_o, busy_o;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    longint e_a = 0, e_b = 0, e_da = 0, e_db = 0;

    always #2 clk = ~clk;

    ripple_comp u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .comp_en_i(comp_en_i),
        .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i), .period_i(period_i),
        .vbus_total_i(vbus_total_i), .vbus_bot_i(vbus_bot_i),
        .vref_top_i(vref_top_i), .vref_bot_i(vref_bot_i),
        .cmp_a_o(cmp_a_o), .cmp_b_o(cmp_b_o), .diff_a_o(diff_a_o),
        .diff_b_o(diff_b_o), .done_o(done_o), .busy_o(busy_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint sc15(input longint a, input longint b);
        return (a * b) >>> 15;
    endfunction

    function automatic longint recip(input longint tot);
        return ((longint'(32767) * 2048) / tot) & 32767;
    endfunction

    // Unclamped balance result of R3
    function automatic longint raw(input longint ta, input longint t, input longint tot,
                                   input longint bot, input longint rt, input longint rb);
        longint v, x;
        v = sc15(t - ta, rt) - sc15(ta, rb);
        x = sc15(t, tot - bot) - v;
        return (x * recip(tot)) >>> 11;
    endfunction

    function automatic longint clampv(input longint n, input longint t);
        if (n >= t) return t - 5;
        if (n <= 0) return 5;
        return n;
    endfunction

    function automatic longint absd(input longint a, input longint b);
        return (a >= b) ? a - b : b - a;
    endfunction

    task automatic wait_done(input string tag);
        int guard;
        guard = 0;
        while (!done_o && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        chk(tag, longint'(done_o), 1);
    endtask

    task automatic apply(input logic en, input logic [15:0] ta, input logic [15:0] tb,
                         input logic [15:0] t, input logic [15:0] tot, input logic [15:0] bot,
                         input logic [15:0] rt, input logic [15:0] rb, input bit inject,
                         input string tag);
        if (!en) begin
            e_a = ta; e_b = tb; e_da = 0; e_db = 0;
        end else if (tot != 0) begin
            e_a  = clampv(raw(ta, t, tot, bot, rt, rb), t);
            e_b  = clampv(raw(tb, t, tot, bot, rt, rb), t);
            e_da = absd(ta, e_a);
            e_db = absd(tb, e_b);
        end
        @(negedge clk);
        comp_en_i = en; cmp_a_i = ta; cmp_b_i = tb; period_i = t;
        vbus_total_i = tot; vbus_bot_i = bot; vref_top_i = rt; vref_bot_i = rb;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (inject) begin
            repeat (3) @(negedge clk);
            comp_en_i = 1'b0; cmp_a_i = 16'h1234; cmp_b_i = 16'h0042;
            period_i = 16'd77; vbus_total_i = 16'h0100;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait_done(tag);
        chk(tag, cmp_a_o, e_a);
        chk(tag, cmp_b_o, e_b);
        chk(tag, diff_a_o, e_da);
        chk(tag, diff_b_o, e_db);
        @(negedge clk);
        chk("R8 done one cycle", done_o, 0);
        chk("R8 outputs stable", cmp_a_o, e_a);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9", cmp_a_o, 0); chk("R9", cmp_b_o, 0);
        chk("R9", diff_a_o, 0); chk("R9", diff_b_o, 0);
        chk("R9", done_o, 0); chk("R9", busy_o, 0);
        rst_n = 1'b1;

        apply(1'b0, 16'd321, 16'd654, 16'd1000, 16'h6000, 16'h3000, 16'h3000, 16'h3000, 1'b0, "R1 bypass");
        apply(1'b1, 16'd300, 16'd700, 16'd1000, 16'h6000, 16'h3000, 16'h3000, 16'h3000, 1'b0, "R2 R3 nominal");
        apply(1'b1, 16'd250, 16'd820, 16'd1334, 16'h5800, 16'h2400, 16'h2C00, 16'h3000, 1'b0, "R3 R6 imbalance");
        apply(1'b1, 16'd900, 16'd900, 16'd1000, 16'h4000, 16'h2000, 16'h0000, 16'h7FFF, 1'b0, "R4 upper clamp");
        chk("R4 upper value", e_a, 995);
        apply(1'b1, 16'd500, 16'd400, 16'd1000, 16'h2000, 16'h4000, 16'h3000, 16'h3000, 1'b0, "R5 lower clamp");
        chk("R5 lower value", e_a, 5);
        apply(1'b1, 16'd111, 16'd222, 16'd1000, 16'h0000, 16'h3000, 16'h3000, 16'h3000, 1'b0, "R7 zero bus hold");
        apply(1'b1, 16'd400, 16'd600, 16'd2000, 16'h6000, 16'h2E00, 16'h3000, 16'h3000, 1'b1, "R10 start while busy");
        chk("R10 busy clear", busy_o, 0);

        for (int i = 0; i < 60; i++) begin
            logic [15:0] t, ta, tb, tot, bot, rt, rb;
            logic        en;
            int          sel;
            sel = int'($urandom_range(0, 9));
            t   = 16'($urandom_range(40, 4000));
            ta  = 16'($urandom_range(0, t));
            tb  = 16'($urandom_range(0, t));
            tot = 16'($urandom_range(16'h1000, 16'h7FFF));
            bot = 16'((tot >> 1) + $urandom_range(0, 16'h0800) - 16'h0400);
            rt  = 16'($urandom_range(16'h2000, 16'h4000));
            rb  = 16'($urandom_range(16'h2000, 16'h4000));
            en  = (sel != 0);
            if (sel == 1) tot = 16'h0000;
            apply(en, ta, tb, t, tot, bot, rt, rb, (sel == 2), "R3 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule